// File: doc/BRIEF.md
# Eight-Bit Arithmetic-Logic Unit with Condition Flags

This block is the execute stage of a small 8-bit processor. Each operation it accepts carries a 4-bit opcode, the destination-register value and the source-register value. One clock later it returns a result byte and a writeback-enable bit. It also keeps a four-bit condition-flag register, which it updates only for arithmetic and logic opcodes. It adds and subtracts with carry and signed-overflow detection. It does bitwise AND, OR and XOR, and shifts the destination operand by exactly one place either way. It multiplies and keeps the low byte, and it divides unsigned, with a defined result for a zero divisor. Compare sets the flags from a subtraction but never requests writeback. Opcodes above compare are memory, branch and halt codes. For those the unit returns a zero result with writeback off and leaves the flag register as it was.

Operands enter over a valid/ready stream and results leave over a second valid/ready stream. A single output register sits between the two. The input is ready whenever that register is empty or is being drained in the same cycle, so the unit sustains one operation per clock when the consumer keeps out_ready high. When out_ready is low while a result is held, the input stalls. The held result, writeback bit and flags then stay unchanged until the consumer takes them. The register file, instruction fetch and sequencing are outside this block.

Top module: `alu8_core`

## Requirements
- R1: An operation is accepted on a rising edge where in_valid and in_ready are both high. Its result appears with out_valid high after that edge. in_ready is high when out_valid is low or out_ready is high. While out_valid is high and out_ready is low, out_data, out_wr and out_flags hold steady and nothing new is accepted.
- R2: After reset, out_valid is 0, out_flags is 4'b0000 and in_ready is 1.
- R3: ADD (opcode 0x0) returns rd+rs mod 256, with C set to the unsigned carry-out and V set when the operands share a sign that the result does not have. SUB (opcode 0x1) returns rd-rs mod 256, with C set when rd >= rs unsigned and V set when the operand signs differ and the result sign differs from rd.
- R4: AND (0x2), OR (0x3) and XOR (0x4) return the bitwise result of rd and rs, and clear C and V.
- R5: SHL (0x5) returns rd shifted left one place with C taken from rd bit 7. SHR (0x6) returns rd shifted right one place with a zero filled in and C taken from rd bit 0. Both clear V, and rs has no effect on either.
- R6: MUL (0x7) returns the low 8 bits of rd*rs. C is set when the upper byte of the full product is non-zero, and V is cleared.
- R7: DIV (0x8) returns the unsigned quotient rd/rs with C clear. A zero rs returns 0xFF with C set. V is cleared in both cases.
- R8: CMP (0x9) updates the flags exactly as SUB would and drives out_data with the difference, but out_wr is 0.
- R9: For opcodes 0x0 to 0x9, out_flags is {Z,N,C,V} (bit 3 down to bit 0). Z is 1 when the result byte is zero and N equals result bit 7. out_wr is 1 for opcodes 0x0 to 0x8.
- R10: Opcodes 0xA to 0xF return out_data 0x00 and out_wr 0, and out_flags keeps the value the previous operation left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_op | input | 4 | Opcode |
| in_rd | input | 8 | Destination-register operand |
| in_rs | input | 8 | Source-register operand |
| out_valid | output | 1 | Result held and offered |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 8 | Result byte |
| out_wr | output | 1 | Destination writeback enable |
| out_flags | output | 4 | Flag register {Z,N,C,V} |

## Verification
A table of directed vectors sits at the sign and carry boundaries: 0x7F+1, 0xFF+1, 0x80-1, 0-1, a multiply that wraps exactly to zero, and a divide by zero. These vectors separate the carry from the overflow rules and the borrow sense of subtraction. A sweep then runs every opcode against all 256 rd values paired with a set of rs values. That set includes the all-ones, sign-bit and alternating patterns, and rs equal to rd. Comparing the sweep with an independent model catches wrong flag conditions in the interior of the range. Running a shift with a non-zero rs shows that rs is ignored. Running a non-ALU opcode right after compare shows that the flags are kept. A stalled consumer with a waiting operation shows that the held result is kept and that the waiting operation is taken on the release cycle.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'h0,
    OP_SUB = 4'h1,
    OP_AND = 4'h2,
    OP_OR  = 4'h3,
    OP_XOR = 4'h4,
    OP_SHL = 4'h5,
    OP_SHR = 4'h6,
    OP_MUL = 4'h7,
    OP_DIV = 4'h8,
    OP_CMP = 4'h9
  } alu_op_e;

  // flag register layout, bit 3 down to bit 0
  typedef struct packed {
    logic z;
    logic n;
    logic c;
    logic v;
  } alu_flags_t;

  localparam int unsigned FLAG_W = 4;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int unsigned W = 8
) (
  input  logic         do_sub,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] res,
  output logic         c_out,
  output logic         v_out
);
  logic [W:0] sum_x;
  logic [W:0] dif_x;
  logic       sa;
  logic       sb;
  logic       sr;

  assign sum_x = {1'b0, opa} + {1'b0, opb};
  assign dif_x = {1'b0, opa} - {1'b0, opb};
  assign sa    = opa[W-1];
  assign sb    = opb[W-1];

  always_comb begin
    if (do_sub) begin
      res   = dif_x[W-1:0];
      sr    = dif_x[W-1];
      c_out = ~dif_x[W];          // no borrow: opa >= opb
      v_out = (sa != sb) && (sr != sa);
    end else begin
      res   = sum_x[W-1:0];
      sr    = sum_x[W-1];
      c_out = sum_x[W];
      v_out = (sa == sb) && (sr != sa);
    end
  end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops #(
  parameter int unsigned W = 8
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] res,
  output logic         c_out
);
  import alu8_pkg::*;

  always_comb begin
    res   = '0;
    c_out = 1'b0;
    unique case (alu_op_e'(op))
      OP_AND: res = opa & opb;
      OP_OR:  res = opa | opb;
      OP_XOR: res = opa ^ opb;
      OP_SHL: begin
        res   = {opa[W-2:0], 1'b0};
        c_out = opa[W-1];
      end
      OP_SHR: begin
        res   = {1'b0, opa[W-1:1]};
        c_out = opa[0];
      end
      default: begin
        res   = '0;
        c_out = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/alu8_muldiv.sv
module alu8_muldiv #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] prod_lo,
  output logic         prod_hi_nz,
  output logic [W-1:0] quot,
  output logic         div_zero
);
  localparam int unsigned PW = 2 * W;

  // shift-and-add multiplier, one partial row per multiplier bit
  logic [PW-1:0] acc [W+1];
  assign acc[0] = '0;

  for (genvar k = 0; k < W; k++) begin : g_mrow
    logic [PW-1:0] row;
    assign row        = opb[k] ? ({{W{1'b0}}, opa} << k) : '0;
    assign acc[k + 1] = acc[k] + row;
  end

  assign prod_lo    = acc[W][W-1:0];
  assign prod_hi_nz = |acc[W][PW-1:W];

  // restoring divider, one stage per quotient bit, MSB first
  logic [W-1:0] rem [W];
  assign rem[0] = '0;

  for (genvar k = 0; k < W; k++) begin : g_dstage
    localparam int unsigned J = W - 1 - k;
    logic [W:0] trial;
    logic       fits;
    assign trial   = {rem[k], opa[J]};
    assign fits    = trial >= {1'b0, opb};
    assign quot[J] = fits;
    if (k < W - 1) begin : g_next
      assign rem[k + 1] = fits ? (trial[W-1:0] - opb) : trial[W-1:0];
    end
  end

  // a zero divisor makes every stage fit, so quot is already all ones
  assign div_zero = (opb == '0);
endmodule

// File: rtl/alu8_core.sv
module alu8_core #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [3:0]   in_op,
  input  logic [W-1:0] in_rd,
  input  logic [W-1:0] in_rs,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         out_wr,
  output logic [3:0]   out_flags
);
  import alu8_pkg::*;

  logic [W-1:0] as_res;
  logic         as_c;
  logic         as_v;
  logic         as_sub;
  logic [W-1:0] bo_res;
  logic         bo_c;
  logic [W-1:0] md_prod;
  logic         md_hi;
  logic [W-1:0] md_quot;
  logic         md_dz;

  assign as_sub = (in_op == OP_SUB) || (in_op == OP_CMP);

  alu8_addsub #(.W(W)) u_addsub (
    .do_sub (as_sub),
    .opa    (in_rd),
    .opb    (in_rs),
    .res    (as_res),
    .c_out  (as_c),
    .v_out  (as_v)
  );

  alu8_bitops #(.W(W)) u_bitops (
    .op     (in_op),
    .opa    (in_rd),
    .opb    (in_rs),
    .res    (bo_res),
    .c_out  (bo_c)
  );

  alu8_muldiv #(.W(W)) u_muldiv (
    .opa        (in_rd),
    .opb        (in_rs),
    .prod_lo    (md_prod),
    .prod_hi_nz (md_hi),
    .quot       (md_quot),
    .div_zero   (md_dz)
  );

  // result select
  logic [W-1:0] nx_data;
  logic         nx_wr;
  logic         nx_upd;
  logic         nx_c;
  logic         nx_v;

  always_comb begin
    nx_data = '0;
    nx_wr   = 1'b0;
    nx_upd  = 1'b0;
    nx_c    = 1'b0;
    nx_v    = 1'b0;
    case (in_op)
      OP_ADD, OP_SUB: begin
        nx_data = as_res;
        nx_wr   = 1'b1;
        nx_upd  = 1'b1;
        nx_c    = as_c;
        nx_v    = as_v;
      end
      OP_CMP: begin
        nx_data = as_res;
        nx_upd  = 1'b1;
        nx_c    = as_c;
        nx_v    = as_v;
      end
      OP_AND, OP_OR, OP_XOR, OP_SHL, OP_SHR: begin
        nx_data = bo_res;
        nx_wr   = 1'b1;
        nx_upd  = 1'b1;
        nx_c    = bo_c;
      end
      OP_MUL: begin
        nx_data = md_prod;
        nx_wr   = 1'b1;
        nx_upd  = 1'b1;
        nx_c    = md_hi;
      end
      OP_DIV: begin
        nx_data = md_quot;
        nx_wr   = 1'b1;
        nx_upd  = 1'b1;
        nx_c    = md_dz;
      end
      default: begin
        nx_data = '0;
      end
    endcase
  end

  alu_flags_t nx_flags;
  assign nx_flags.z = (nx_data == '0);
  assign nx_flags.n = nx_data[W-1];
  assign nx_flags.c = nx_c;
  assign nx_flags.v = nx_v;

  // single output stage
  logic         take;
  logic         full_q;
  logic [W-1:0] data_q;
  logic         wr_q;
  alu_flags_t   flags_q;

  assign in_ready = ~full_q | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      data_q  <= '0;
      wr_q    <= 1'b0;
      flags_q <= '0;
    end else begin
      if (take) begin
        full_q <= 1'b1;
        data_q <= nx_data;
        wr_q   <= nx_wr;
        if (nx_upd) begin
          flags_q <= nx_flags;
        end
      end else if (out_ready) begin
        full_q <= 1'b0;
      end
    end
  end

  assign out_valid = full_q;
  assign out_data  = data_q;
  assign out_wr    = wr_q;
  assign out_flags = flags_q;
endmodule

// File: rtl/alu8_chk.sv
module alu8_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [3:0]   in_op,
  input logic [W-1:0] in_rd,
  input logic [W-1:0] in_rs,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data,
  input logic         out_wr,
  input logic [3:0]   out_flags
);
  logic acc_ok;
  assign acc_ok = in_valid && in_ready;

  // R1
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_wr) && $stable(out_flags)));

  // R1
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok |=> out_valid);

  // R5
  shl_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && in_op == 4'h5) |=> (out_data == {$past(in_rd[W-2:0]), 1'b0} && out_flags[1] == $past(in_rd[W-1])));

  // R8
  cmp_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && in_op == 4'h9) |=> !out_wr);

  // R9
  zn_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && in_op <= 4'h9) |=> (out_flags[3] == (out_data == '0) && out_flags[2] == out_data[W-1]));

  // R10
  keep_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && in_op >= 4'hA) |=> (!out_wr && out_data == '0 && $stable(out_flags)));
endmodule

bind alu8_core alu8_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_op     (in_op),
  .in_rd     (in_rd),
  .in_rs     (in_rs),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_wr    (out_wr),
  .out_flags (out_flags)
);

// File: tb/alu8_core_tb.sv
`timescale 1ns/1ps
module alu8_core_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [3:0] in_op = '0;
  logic [7:0] in_rd = '0;
  logic [7:0] in_rs = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;
  logic       out_wr;
  logic [3:0] out_flags;

  int checks = 0;
  int errors = 0;
  logic [3:0] mdl_flags = '0;

  always #4 clk = ~clk;

  alu8_core #(.W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_rd(in_rd), .in_rs(in_rs), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_wr(out_wr), .out_flags(out_flags)
  );

  // {op, rd, rs, data, wr, flags ZNCV}
  localparam logic [32:0] VEC [16] = '{
    {4'h0, 8'h7F, 8'h01, 8'h80, 1'b1, 4'b0101},
    {4'h0, 8'hFF, 8'h01, 8'h00, 1'b1, 4'b1010},
    {4'h1, 8'h05, 8'h05, 8'h00, 1'b1, 4'b1010},
    {4'h1, 8'h00, 8'h01, 8'hFF, 1'b1, 4'b0100},
    {4'h1, 8'h80, 8'h01, 8'h7F, 1'b1, 4'b0011},
    {4'h2, 8'hF0, 8'h3C, 8'h30, 1'b1, 4'b0000},
    {4'h3, 8'h00, 8'h00, 8'h00, 1'b1, 4'b1000},
    {4'h4, 8'hAA, 8'h55, 8'hFF, 1'b1, 4'b0100},
    {4'h5, 8'h81, 8'h77, 8'h02, 1'b1, 4'b0010},
    {4'h6, 8'h81, 8'h77, 8'h40, 1'b1, 4'b0010},
    {4'h7, 8'h10, 8'h10, 8'h00, 1'b1, 4'b1010},
    {4'h7, 8'h0C, 8'h0B, 8'h84, 1'b1, 4'b0100},
    {4'h8, 8'hC8, 8'h07, 8'h1C, 1'b1, 4'b0000},
    {4'h8, 8'h05, 8'h00, 8'hFF, 1'b1, 4'b0110},
    {4'h9, 8'h03, 8'h09, 8'hFA, 1'b0, 4'b0100},
    {4'hC, 8'h12, 8'h34, 8'h00, 1'b0, 4'b0100}
  };

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'h0, 4'h1: return "R3";
      4'h2, 4'h3, 4'h4: return "R4";
      4'h5, 4'h6: return "R5";
      4'h7: return "R6";
      4'h8: return "R7";
      4'h9: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input logic ok, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // independent reference; updates the model flag register
  task automatic model(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                       output logic [7:0] d, output logic wr, output logic [3:0] f);
    int s;
    logic c;
    logic v;
    c = 1'b0; v = 1'b0; d = '0; wr = (op <= 4'h8);
    case (op)
      4'h0: begin s = int'(a) + int'(b); d = s[7:0]; c = (s > 255); v = (a[7] == b[7]) && (d[7] != a[7]); end
      4'h1, 4'h9: begin d = a - b; c = (a >= b); v = (a[7] != b[7]) && (d[7] != a[7]); end
      4'h2: d = a & b;
      4'h3: d = a | b;
      4'h4: d = a ^ b;
      4'h5: begin d = {a[6:0], 1'b0}; c = a[7]; end
      4'h6: begin d = {1'b0, a[7:1]}; c = a[0]; end
      4'h7: begin s = int'(a) * int'(b); d = s[7:0]; c = (s > 255); end
      4'h8: begin if (b == 0) begin d = 8'hFF; c = 1'b1; end else d = a / b; end
      default: d = '0;
    endcase
    if (op <= 4'h9) mdl_flags = {(d == 8'h00), d[7], c, v};
    f = mdl_flags;
  endtask

  task automatic issue(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    in_op = op; in_rd = a; in_rs = b; in_valid = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_one(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
    logic [7:0] d;
    logic wr;
    logic [3:0] f;
    model(op, a, b, d, wr, f);
    issue(op, a, b);
    check(req_of(op), out_valid, "R1 out_valid", int'(out_valid), 1);
    check(req_of(op), out_data == d, "data", int'(out_data), int'(d));
    check(req_of(op), out_wr == wr, "wr (R9)", int'(out_wr), int'(wr));
    check(req_of(op), out_flags == f, "flags (R9)", int'(out_flags), int'(f));
  endtask

  logic [7:0] rs_set [12] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h07, 8'h10,
                             8'h55, 8'h7F, 8'h80, 8'h81, 8'hAA, 8'hFF};

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R2 reset state
    check("R2", out_valid == 1'b0, "out_valid", int'(out_valid), 0);
    check("R2", out_flags == 4'b0000, "flags", int'(out_flags), 0);
    check("R2", in_ready == 1'b1, "in_ready", int'(in_ready), 1);
    rst_n = 1'b1;

    // vector table
    for (int i = 0; i < 16; i++) begin
      logic [3:0] op;
      op = VEC[i][32:29];
      issue(op, VEC[i][28:21], VEC[i][20:13]);
      check(req_of(op), out_data == VEC[i][12:5], "table data", int'(out_data), int'(VEC[i][12:5]));
      check(req_of(op), out_wr == VEC[i][4], "table wr", int'(out_wr), int'(VEC[i][4]));
      check(req_of(op), out_flags == VEC[i][3:0], "table flags", int'(out_flags), int'(VEC[i][3:0]));
    end
    mdl_flags = 4'b0100;

    // R1: result leaves after one cycle with out_ready high
    @(negedge clk);
    check("R1", out_valid == 1'b0, "drained", int'(out_valid), 0);

    // R5: rs has no effect on a shift
    run_one(4'h5, 8'h3C, 8'h00);
    run_one(4'h5, 8'h3C, 8'hFF);
    check("R5", out_data == 8'h78, "shl rs ignored", int'(out_data), 8'h78);

    // R1 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    in_op = 4'h0; in_rd = 8'h01; in_rs = 8'h02; in_valid = 1'b1;
    @(posedge clk);
    #1 in_op = 4'h1; in_rd = 8'h09; in_rs = 8'h04;
    @(negedge clk);
    check("R1", in_ready == 1'b0, "stall in_ready", int'(in_ready), 0);
    @(posedge clk);
    @(negedge clk);
    check("R1", out_data == 8'h03, "held data", int'(out_data), 3);
    check("R1", out_valid == 1'b1, "held valid", int'(out_valid), 1);
    out_ready = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    check("R1", out_data == 8'h05, "release takes waiting op", int'(out_data), 5);
    check("R1", out_flags == 4'b0010, "release flags", int'(out_flags), 2);
    mdl_flags = 4'b0010;

    // R10 right after flags set: kept
    run_one(4'hF, 8'hFF, 8'hFF);

    // sweep over every opcode
    for (int op = 0; op < 16; op++) begin
      for (int a = 0; a < 256; a++) begin
        for (int j = 0; j < 12; j++) begin
          run_one(op[3:0], a[7:0], rs_set[j]);
        end
        run_one(op[3:0], a[7:0], a[7:0]);
      end
    end

    // R2 reset mid-run clears flags
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R2", out_flags == 4'b0000, "flags after reset", int'(out_flags), 0);
    check("R2", out_valid == 1'b0, "valid after reset", int'(out_valid), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule